// File: doc/BRIEF.md
# Shared Class-of-Service Allocator

This block hands out class-of-service (COS) IDs on one socket. Many domains share a small pool of COS IDs, and each COS stands for a tuple of cache capacity masks. With L3 allocation off the tuple is just the L2 mask. With L3 allocation on it is the pair L2 mask and L3 mask. In code/data mode it is the triple L2 mask, L3 code mask and L3 data mask. The block keeps a shadow copy of every stored tuple and a use count for every COS.

A request names the COS the domain uses now, the component to change and the new mask. The block copies the old tuple and replaces that one component. It then walks the pool one COS per clock, looking for a COS that already holds the same tuple and for the lowest unused COS. If the old COS has no other user, it can be rewritten in place. When a COS has to take on new values, the block sends mask-write commands to the external mask table, one per cycle. It finishes with a one-cycle done pulse that carries a status code and the COS the domain should use from then on.

COS 0 is the default class with all-ones masks. It is never rewritten, and a tuple made only of defaults always maps to it.

Top module: `cos_share_alloc`

## Requirements
- R1: After reset, busy, done and wr_valid are low, every use count is zero and every COS holds the all-ones tuple.
- R2: A request is taken only while busy is low. busy is high from the cycle after acceptance until completion, and a request raised while busy is high is ignored.
- R3: The new tuple is the old COS's tuple with only the named component replaced. Component codes are 0 for L2, 1 for L3 (both halves), 2 for L3 code and 3 for L3 data. When L3 is off, only the L2 member is compared. If the lowest-numbered COS that holds an equal tuple also fits, that COS is returned with status 0 and no writes. The old COS count drops by one and the returned COS count rises by one; the count of COS 0 never changes.
- R4: When there is no match and no in-place update, the lowest COS at or above 1 that has count zero and fits is claimed. Writes go out in this order: L2 as component 0, then L3 as component 1 (L3 on, code/data mode off), or L3 code as 2 then L3 data as 3 (code/data mode).
- R5: When there is no match, the old COS is not 0, its count is 1 and it fits the new tuple, that COS is rewritten in place. Only the changed component is written: component 1 in code/data mode gives two writes (2, then 3).
- R6: No mask write ever targets COS 0. A request whose new tuple is all ones returns COS 0.
- R7: A candidate COS fits when it is at most L2_COS_MAX or the new L2 mask is all ones, and, with L3 on, when it is at most the L3 limit or both L3 members are all ones. The L3 limit is L3_COS_MAX, or (L3_COS_MAX+1)/2-1 in code/data mode.
- R8: When no COS matches or is free, the request ends with status 1 (no space), returns the old COS and issues no writes. Counts and tuples are left unchanged.
- R9: A request ends with status 2 (bad request) and changes nothing in these cases: the component is not allowed in the mode (1 to 3 with L3 off, 2 or 3 without code/data mode), the old COS is out of range, or the old COS is not 0 and has count zero.
- R10: done is a one-cycle pulse, NUM_COS+1+W cycles after the acceptance edge, where W is the number of writes. The writes appear one per cycle in the W cycles just before done, and busy is low in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l3_en | input | 1 | L3 allocation on (static after reset) |
| cdp_en | input | 1 | Code/data mode on (static after reset) |
| req_valid | input | 1 | Request strobe |
| req_cos | input | COS_W | COS the domain uses now |
| req_comp | input | 2 | Component to change |
| req_mask | input | MASK_W | New mask for that component |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Completion pulse |
| done_status | output | 2 | 0 ok, 1 no space, 2 bad request |
| done_cos | output | COS_W | COS to use from now on |
| wr_valid | output | 1 | Mask-write command valid |
| wr_cos | output | COS_W | COS whose mask is written |
| wr_comp | output | 2 | Component written (codes as in R4) |
| wr_mask | output | MASK_W | Mask value to write |

## Verification
Every result follows the acceptance edge after a fixed count of edges. The scan takes NUM_COS edges and the decision one more, so a request with no writes shows done on the NUM_COS+1th edge. A request with W writes shows them on edges NUM_COS+1 through NUM_COS+W and done one edge later. The bench counts falling edges from acceptance, records each write with its cycle number, and compares both the cycle numbers and the values against a model of counts and tuples that it updates from the requirements. It also checks that busy is high in the first cycle after acceptance and low two cycles after done, even when a stray request is driven during the scan.

// File: rtl/cos_alloc_pkg.sv
package cos_alloc_pkg;

    localparam int MASK_W = 8;

    typedef logic [MASK_W-1:0] mask_t;

    localparam mask_t MASK_ONES = '1;

    typedef struct packed {
        mask_t l2;
        mask_t l3c;
        mask_t l3d;
    } tuple_t;

    localparam tuple_t TUPLE_DEFAULT = '1;

    typedef enum logic [1:0] {
        COMP_L2   = 2'd0,
        COMP_L3   = 2'd1,
        COMP_CODE = 2'd2,
        COMP_DATA = 2'd3
    } comp_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NOSPACE = 2'd1,
        RES_BADREQ  = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RESOLVE,
        ST_WRITE
    } state_e;

    // Equality over the members that are active in the current mode.
    function automatic logic tuple_equal(tuple_t a, tuple_t b, logic l3_on);
        return (a.l2 == b.l2) && (!l3_on || ((a.l3c == b.l3c) && (a.l3d == b.l3d)));
    endfunction

    // Range check of a candidate COS against every feature holding a non-default value.
    function automatic logic tuple_fits(int idx, tuple_t t, logic l3_on, logic cdp_on,
                                        int l2_max, int l3_max);
        int  l3_lim;
        logic ok_l2;
        logic ok_l3;
        l3_lim = cdp_on ? ((l3_max + 1) / 2 - 1) : l3_max;
        ok_l2  = (t.l2 == MASK_ONES) || (idx <= l2_max);
        ok_l3  = !l3_on || ((t.l3c == MASK_ONES) && (t.l3d == MASK_ONES)) || (idx <= l3_lim);
        return ok_l2 && ok_l3;
    endfunction

endpackage

// File: rtl/cos_tuple_merge.sv
module cos_tuple_merge
    import cos_alloc_pkg::*;
(
    input  tuple_t      base_i,
    input  logic [1:0]  comp_i,
    input  mask_t       mask_i,
    input  logic        l3_en_i,
    input  logic        cdp_en_i,
    output tuple_t      merged_o,
    output logic        legal_o
);

    always_comb begin
        merged_o = base_i;
        legal_o  = 1'b0;
        case (comp_e'(comp_i))
            COMP_L2: begin
                merged_o.l2 = mask_i;
                legal_o     = 1'b1;
            end
            COMP_L3: begin
                merged_o.l3c = mask_i;
                merged_o.l3d = mask_i;
                legal_o      = l3_en_i;
            end
            COMP_CODE: begin
                merged_o.l3c = mask_i;
                legal_o      = l3_en_i & cdp_en_i;
            end
            default: begin
                merged_o.l3d = mask_i;
                legal_o      = l3_en_i & cdp_en_i;
            end
        endcase
    end

endmodule

// File: rtl/cos_scan_unit.sv
module cos_scan_unit
    import cos_alloc_pkg::*;
#(
    parameter int COS_W      = 3,
    parameter int L2_COS_MAX = 3,
    parameter int L3_COS_MAX = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_i,
    input  logic [COS_W-1:0] idx_i,
    input  tuple_t           entry_i,
    input  logic             entry_idle_i,
    input  tuple_t           target_i,
    input  logic             l3_en_i,
    input  logic             cdp_en_i,
    output logic             match_found_o,
    output logic [COS_W-1:0] match_idx_o,
    output logic             free_found_o,
    output logic [COS_W-1:0] free_idx_o
);

    logic fit;
    logic hit;
    logic spare;

    always_comb begin
        fit   = tuple_fits(int'(idx_i), target_i, l3_en_i, cdp_en_i, L2_COS_MAX, L3_COS_MAX);
        hit   = tuple_equal(entry_i, target_i, l3_en_i) && fit;
        spare = (idx_i != '0) && entry_idle_i && fit;
    end

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            match_found_o <= 1'b0;
            match_idx_o   <= '0;
            free_found_o  <= 1'b0;
            free_idx_o    <= '0;
        end else if (step_i) begin
            if (!match_found_o && hit) begin
                match_found_o <= 1'b1;
                match_idx_o   <= idx_i;
            end
            if (!free_found_o && spare) begin
                free_found_o <= 1'b1;
                free_idx_o   <= idx_i;
            end
        end
    end

endmodule

// File: rtl/cos_write_seq.sv
module cos_write_seq
    import cos_alloc_pkg::*;
#(
    parameter int COS_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [2:0]       set_i,
    input  logic [COS_W-1:0] cos_i,
    input  tuple_t           tuple_i,
    input  logic             cdp_en_i,
    output logic             last_o,
    output logic             wr_valid_o,
    output logic [COS_W-1:0] wr_cos_o,
    output logic [1:0]       wr_comp_o,
    output mask_t            wr_mask_o
);

    logic [2:0]       pend_q;
    logic [2:0]       sel;
    logic [COS_W-1:0] cos_q;
    tuple_t           tuple_q;

    always_comb begin
        sel        = pend_q & (~pend_q + 3'd1);
        wr_valid_o = (pend_q != 3'd0);
        last_o     = wr_valid_o && ((pend_q & (pend_q - 3'd1)) == 3'd0);
        wr_cos_o   = cos_q;
        wr_comp_o  = COMP_L2;
        wr_mask_o  = '0;
        if (sel[0]) begin
            wr_comp_o = COMP_L2;
            wr_mask_o = tuple_q.l2;
        end else if (sel[1]) begin
            wr_comp_o = cdp_en_i ? COMP_CODE : COMP_L3;
            wr_mask_o = tuple_q.l3c;
        end else if (sel[2]) begin
            wr_comp_o = COMP_DATA;
            wr_mask_o = tuple_q.l3d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 3'd0;
            cos_q   <= '0;
            tuple_q <= TUPLE_DEFAULT;
        end else if (load_i) begin
            pend_q  <= set_i;
            cos_q   <= cos_i;
            tuple_q <= tuple_i;
        end else begin
            pend_q <= pend_q & ~sel;
        end
    end

endmodule

// File: rtl/cos_share_alloc.sv
module cos_share_alloc
    import cos_alloc_pkg::*;
#(
    parameter  int NUM_COS    = 8,
    parameter  int L2_COS_MAX = 3,
    parameter  int L3_COS_MAX = 7,
    parameter  int CNT_W      = 8,
    localparam int COS_W      = (NUM_COS > 1) ? $clog2(NUM_COS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l3_en,
    input  logic              cdp_en,
    input  logic              req_valid,
    input  logic [COS_W-1:0]  req_cos,
    input  logic [1:0]        req_comp,
    input  logic [MASK_W-1:0] req_mask,
    output logic              busy,
    output logic              done,
    output logic [1:0]        done_status,
    output logic [COS_W-1:0]  done_cos,
    output logic              wr_valid,
    output logic [COS_W-1:0]  wr_cos,
    output logic [1:0]        wr_comp,
    output logic [MASK_W-1:0] wr_mask
);

    localparam logic [COS_W-1:0] LAST_IDX = COS_W'(NUM_COS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    state_e           state_q;
    logic [COS_W-1:0] idx_q;
    logic [COS_W-1:0] old_q;
    tuple_t           new_q;
    logic             bad_q;
    logic [1:0]       comp_q;
    logic             done_q;
    logic [1:0]       status_q;
    logic [COS_W-1:0] dcos_q;

    tuple_t           shad_q [NUM_COS];
    tuple_t           shad_d [NUM_COS];
    logic [CNT_W-1:0] cnt_q  [NUM_COS];
    logic [CNT_W-1:0] cnt_d  [NUM_COS];

    // Request side
    logic [COS_W:0]   req_ext;
    logic             req_in_range;
    tuple_t           base_t;
    tuple_t           merged_t;
    logic             legal;
    logic             req_bad;
    logic             accept;

    always_comb begin
        req_ext      = {1'b0, req_cos};
        req_in_range = req_ext < (COS_W+1)'(NUM_COS);
        base_t       = req_in_range ? shad_q[req_cos] : TUPLE_DEFAULT;
        req_bad      = !legal || !req_in_range ||
                       ((req_cos != '0) && (cnt_q[req_cos] == '0));
        accept       = (state_q == ST_IDLE) && req_valid;
    end

    cos_tuple_merge u_merge (
        .base_i   (base_t),
        .comp_i   (req_comp),
        .mask_i   (req_mask),
        .l3_en_i  (l3_en),
        .cdp_en_i (cdp_en),
        .merged_o (merged_t),
        .legal_o  (legal)
    );

    // Pool walk
    logic             match_found;
    logic [COS_W-1:0] match_idx;
    logic             free_found;
    logic [COS_W-1:0] free_idx;

    cos_scan_unit #(
        .COS_W      (COS_W),
        .L2_COS_MAX (L2_COS_MAX),
        .L3_COS_MAX (L3_COS_MAX)
    ) u_scan (
        .clk           (clk),
        .rst           (rst),
        .start_i       (accept),
        .step_i        (state_q == ST_SCAN),
        .idx_i         (idx_q),
        .entry_i       (shad_q[idx_q]),
        .entry_idle_i  (cnt_q[idx_q] == '0),
        .target_i      (new_q),
        .l3_en_i       (l3_en),
        .cdp_en_i      (cdp_en),
        .match_found_o (match_found),
        .match_idx_o   (match_idx),
        .free_found_o  (free_found),
        .free_idx_o    (free_idx)
    );

    // Decision
    logic             inplace_ok;
    logic             use_match;
    logic             use_inplace;
    logic             use_free;
    logic             resolving;
    logic [2:0]       inplace_set;
    logic [2:0]       fresh_set;
    logic             seq_load;
    logic [2:0]       seq_set;
    logic [COS_W-1:0] seq_cos;
    logic             seq_last;

    always_comb begin
        resolving  = (state_q == ST_RESOLVE);
        inplace_ok = (old_q != '0) && (cnt_q[old_q] == CNT_ONE) &&
                     tuple_fits(int'(old_q), new_q, l3_en, cdp_en, L2_COS_MAX, L3_COS_MAX);
        use_match   = !bad_q && match_found;
        use_inplace = !bad_q && !match_found && inplace_ok;
        use_free    = !bad_q && !match_found && !inplace_ok && free_found;
        case (comp_e'(comp_q))
            COMP_L2:   inplace_set = 3'b001;
            COMP_L3:   inplace_set = cdp_en ? 3'b110 : 3'b010;
            COMP_CODE: inplace_set = 3'b010;
            default:   inplace_set = 3'b100;
        endcase
        fresh_set = !l3_en ? 3'b001 : (cdp_en ? 3'b111 : 3'b011);
        seq_load  = resolving && (use_inplace || use_free);
        seq_set   = use_inplace ? inplace_set : fresh_set;
        seq_cos   = use_inplace ? old_q : free_idx;
    end

    always_comb begin
        for (int i = 0; i < NUM_COS; i++) begin
            cnt_d[i]  = cnt_q[i];
            shad_d[i] = shad_q[i];
        end
        if (resolving) begin
            if (use_match) begin
                if (match_idx != old_q) begin
                    if (old_q != '0)     cnt_d[old_q]     = cnt_q[old_q] - CNT_ONE;
                    if (match_idx != '0) cnt_d[match_idx] = cnt_q[match_idx] + CNT_ONE;
                end
            end else if (use_inplace) begin
                shad_d[old_q] = new_q;
            end else if (use_free) begin
                if (old_q != '0) cnt_d[old_q] = cnt_q[old_q] - CNT_ONE;
                cnt_d[free_idx]  = cnt_q[free_idx] + CNT_ONE;
                shad_d[free_idx] = new_q;
            end
        end
    end

    cos_write_seq #(
        .COS_W (COS_W)
    ) u_wseq (
        .clk        (clk),
        .rst        (rst),
        .load_i     (seq_load),
        .set_i      (seq_set),
        .cos_i      (seq_cos),
        .tuple_i    (new_q),
        .cdp_en_i   (cdp_en),
        .last_o     (seq_last),
        .wr_valid_o (wr_valid),
        .wr_cos_o   (wr_cos),
        .wr_comp_o  (wr_comp),
        .wr_mask_o  (wr_mask)
    );

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_COS; i++) begin
            cnt_q[i]  <= rst ? '0 : cnt_d[i];
            shad_q[i] <= rst ? TUPLE_DEFAULT : shad_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            old_q    <= '0;
            new_q    <= TUPLE_DEFAULT;
            bad_q    <= 1'b0;
            comp_q   <= 2'd0;
            done_q   <= 1'b0;
            status_q <= RES_OK;
            dcos_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        old_q   <= req_cos;
                        new_q   <= merged_t;
                        bad_q   <= req_bad;
                        comp_q  <= req_comp;
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) state_q <= ST_RESOLVE;
                end
                ST_RESOLVE: begin
                    if (bad_q) begin
                        status_q <= RES_BADREQ;
                        dcos_q   <= old_q;
                    end else if (use_match) begin
                        status_q <= RES_OK;
                        dcos_q   <= match_idx;
                    end else if (use_inplace) begin
                        status_q <= RES_OK;
                        dcos_q   <= old_q;
                    end else if (use_free) begin
                        status_q <= RES_OK;
                        dcos_q   <= free_idx;
                    end else begin
                        status_q <= RES_NOSPACE;
                        dcos_q   <= old_q;
                    end
                    if (seq_load) begin
                        state_q <= ST_WRITE;
                    end else begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    if (seq_last) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign done_status = status_q;
    assign done_cos    = dcos_q;

endmodule

// File: rtl/cos_share_alloc_chk.sv
module cos_share_alloc_chk
    import cos_alloc_pkg::*;
#(
    parameter int COS_W      = 3,
    parameter int L2_COS_MAX = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              wr_valid,
    input logic [COS_W-1:0]  wr_cos,
    input logic [1:0]        wr_comp,
    input logic [MASK_W-1:0] wr_mask
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && !wr_valid));

    a_r2_busy_needs_request: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r4_write_in_request: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

    a_r6_default_untouched: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_cos != '0));

    a_r7_l2_range: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && (wr_comp == 2'd0) && (wr_mask != MASK_ONES)) |-> (int'(wr_cos) <= L2_COS_MAX));

endmodule

bind cos_share_alloc cos_share_alloc_chk #(
    .COS_W      (COS_W),
    .L2_COS_MAX (L2_COS_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .wr_valid  (wr_valid),
    .wr_cos    (wr_cos),
    .wr_comp   (wr_comp),
    .wr_mask   (wr_mask)
);

// File: tb/cos_share_alloc_test.sv
`timescale 1ns/1ps
module cos_share_alloc_test;

    localparam int NCOS  = 8;
    localparam int L2MAX = 3;
    localparam int L3MAX = 7;
    localparam int NDOM  = 6;
    localparam int CW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          l3_en = 1'b1;
    logic          cdp_en = 1'b0;
    logic          req_valid = 1'b0;
    logic [CW-1:0] req_cos = '0;
    logic [1:0]    req_comp = '0;
    logic [7:0]    req_mask = '0;
    logic          busy, done, wr_valid;
    logic [1:0]    done_status, wr_comp;
    logic [CW-1:0] done_cos, wr_cos;
    logic [7:0]    wr_mask;

    always #4 clk = ~clk;

    cos_share_alloc #(.NUM_COS(NCOS), .L2_COS_MAX(L2MAX), .L3_COS_MAX(L3MAX), .CNT_W(8)) uut (
        .clk(clk), .rst(rst), .l3_en(l3_en), .cdp_en(cdp_en),
        .req_valid(req_valid), .req_cos(req_cos), .req_comp(req_comp), .req_mask(req_mask),
        .busy(busy), .done(done), .done_status(done_status), .done_cos(done_cos),
        .wr_valid(wr_valid), .wr_cos(wr_cos), .wr_comp(wr_comp), .wr_mask(wr_mask)
    );

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    int m_l2 [NCOS];
    int m_c  [NCOS];
    int m_d  [NCOS];
    int m_cnt[NCOS];
    int dom_cos[NDOM];
    int last_cos, last_stat;
    logic [15:0] lfsr = 16'hACE1;

    int masks [7] = '{8'hff, 8'h0f, 8'hf0, 8'h3c, 8'h03, 8'hc0, 8'h7f};

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic bit mfits(int i, int a, int b, int c);
        int lim;
        lim = cdp_en ? ((L3MAX + 1) / 2 - 1) : L3MAX;
        return ((a == 255) || (i <= L2MAX)) &&
               (!l3_en || ((b == 255) && (c == 255)) || (i <= lim));
    endfunction

    function automatic int rnd(int n);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr) % n;
    endfunction

    task automatic do_reset(input bit l3, input bit cdp);
        @(negedge clk);
        rst = 1'b1; l3_en = l3; cdp_en = cdp; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NCOS; i++) begin
            m_l2[i] = 255; m_c[i] = 255; m_d[i] = 255; m_cnt[i] = 0;
        end
        for (int d = 0; d < NDOM; d++) dom_cos[d] = 0;
        chk(!busy && !done && !wr_valid, "R1", "idle after reset", {busy, done, wr_valid}, 0);
    endtask

    task automatic issue(input int oc, input int comp, input int mask, input string ftag, input bit junk);
        int nl2, nc, nd, match, free, kind, ecos, estat, en, gn, dlat, lat3, idx;
        int ew_cos[3], ew_comp[3], ew_mask[3];
        int gw_cos[4], gw_comp[4], gw_mask[4], gw_k[4];
        bit bad, l3, cdp;
        string tg;
        l3 = l3_en; cdp = cdp_en;
        bad = !((comp == 0) || (l3 && comp == 1) || (l3 && cdp && comp >= 2)) ||
              (oc >= NCOS) || ((oc != 0) && (m_cnt[oc] == 0));
        nl2 = 255; nc = 255; nd = 255;
        if (oc < NCOS) begin nl2 = m_l2[oc]; nc = m_c[oc]; nd = m_d[oc]; end
        case (comp)
            0: nl2 = mask;
            1: begin nc = mask; nd = mask; end
            2: nc = mask;
            default: nd = mask;
        endcase
        match = -1; free = -1;
        for (int i = 0; i < NCOS; i++) begin
            if (match < 0 && m_l2[i] == nl2 && (!l3 || (m_c[i] == nc && m_d[i] == nd)) && mfits(i, nl2, nc, nd))
                match = i;
            if (free < 0 && i != 0 && m_cnt[i] == 0 && mfits(i, nl2, nc, nd))
                free = i;
        end
        en = 0; ecos = oc; estat = 0;
        if (bad) begin kind = 0; estat = 2; end
        else if (match >= 0) begin
            kind = 1; ecos = match;
            if (match != oc) begin
                if (oc != 0) m_cnt[oc]--;
                if (match != 0) m_cnt[match]++;
            end
        end else if (oc != 0 && m_cnt[oc] == 1 && mfits(oc, nl2, nc, nd)) begin
            kind = 2;
            if (comp == 0) begin ew_cos[0] = oc; ew_comp[0] = 0; ew_mask[0] = nl2; en = 1; end
            else if (comp == 1 && !cdp) begin ew_cos[0] = oc; ew_comp[0] = 1; ew_mask[0] = nc; en = 1; end
            else begin
                if (comp != 3) begin ew_cos[en] = oc; ew_comp[en] = 2; ew_mask[en] = nc; en++; end
                if (comp != 2) begin ew_cos[en] = oc; ew_comp[en] = 3; ew_mask[en] = nd; en++; end
            end
            m_l2[oc] = nl2; m_c[oc] = nc; m_d[oc] = nd;
        end else if (free >= 0) begin
            kind = 3; ecos = free;
            ew_cos[0] = free; ew_comp[0] = 0; ew_mask[0] = nl2; en = 1;
            if (l3) begin
                if (cdp) begin
                    ew_cos[1] = free; ew_comp[1] = 2; ew_mask[1] = nc;
                    ew_cos[2] = free; ew_comp[2] = 3; ew_mask[2] = nd; en = 3;
                end else begin
                    ew_cos[1] = free; ew_comp[1] = 1; ew_mask[1] = nc; en = 2;
                end
            end
            if (oc != 0) m_cnt[oc]--;
            m_cnt[free]++;
            m_l2[free] = nl2; m_c[free] = nc; m_d[free] = nd;
        end else begin kind = 4; estat = 1; end
        case (kind)
            0: tg = "R9";
            1: tg = "R3";
            2: tg = "R5";
            3: tg = "R4";
            default: tg = "R8";
        endcase
        if (ftag != "") tg = ftag;

        // drive
        @(negedge clk);
        chk(!busy, "R2", "idle before request", busy, 0);
        req_valid = 1'b1; req_cos = CW'(oc); req_comp = 2'(comp); req_mask = 8'(mask);
        @(negedge clk);
        chk(busy, "R2", "busy after accept", busy, 1);
        if (junk) begin
            req_cos = CW'(rnd(NCOS)); req_comp = 2'(rnd(4)); req_mask = 8'(rnd(256));
        end else req_valid = 1'b0;
        gn = 0; dlat = -1;
        for (int k = 0; k < 40; k++) begin
            if (k == 1) req_valid = 1'b0;
            if (wr_valid && gn < 4) begin
                gw_cos[gn] = int'(wr_cos); gw_comp[gn] = int'(wr_comp); gw_mask[gn] = int'(wr_mask);
                gw_k[gn] = k; gn++;
            end
            if (done) begin dlat = k; break; end
            @(negedge clk);
        end
        lat3 = NCOS + 1 + en;
        chk(dlat == lat3, "R10", "done latency", dlat, lat3);
        chk(int'(done_status) == estat, tg, "status", int'(done_status), estat);
        chk(int'(done_cos) == ecos, tg, "cos", int'(done_cos), ecos);
        chk(gn == en, tg, "write count", gn, en);
        for (int w = 0; w < 3; w++) begin
            if (w < en && w < gn) begin
                chk(gw_cos[w] == ew_cos[w], tg, "write cos", gw_cos[w], ew_cos[w]);
                chk(gw_comp[w] == ew_comp[w], tg, "write comp", gw_comp[w], ew_comp[w]);
                chk(gw_mask[w] == ew_mask[w], tg, "write mask", gw_mask[w], ew_mask[w]);
                chk(gw_k[w] == NCOS + 1 + w, "R10", "write cycle", gw_k[w], NCOS + 1 + w);
            end
        end
        @(negedge clk);
        @(negedge clk);
        idx = int'(busy);
        chk(idx == 0 && !done, "R2", "no activity after done", idx, 0);
        last_cos = int'(done_cos); last_stat = int'(done_status);
    endtask

    task automatic dom_req(input int d, input int comp, input int mask, input string tg, input bit junk);
        issue(dom_cos[d], comp, mask, tg, junk);
        if (last_stat == 0) dom_cos[d] = last_cos;
    endtask

    task automatic sweep(input int n, input int mode);
        int d, c, m;
        for (int t = 0; t < n; t++) begin
            d = rnd(NDOM);
            m = masks[rnd(7)];
            if (mode == 0) c = (rnd(8) == 0) ? 1 + rnd(3) : 0;
            else if (mode == 1) c = (rnd(8) == 0) ? 2 + rnd(2) : rnd(2);
            else c = rnd(4);
            if (rnd(16) == 0) issue(7, c, m, "", rnd(2) == 1);
            else dom_req(d, c, m, "", rnd(4) == 0);
        end
    endtask

    initial begin
        // L3 on, code/data off
        do_reset(1'b1, 1'b0);
        dom_req(0, 0, 8'h0f, "R4", 1'b0);
        chk(last_cos == 1, "R4", "lowest free", last_cos, 1);
        dom_req(1, 0, 8'h0f, "R3", 1'b0);
        dom_req(0, 1, 8'h3c, "R4", 1'b1);
        dom_req(1, 1, 8'h3c, "R3", 1'b0);
        chk(last_cos == 2, "R3", "shared cos", last_cos, 2);
        dom_req(2, 0, 8'hf0, "R4", 1'b0);
        chk(last_cos == 1, "R4", "reclaimed cos", last_cos, 1);
        dom_req(2, 0, 8'hff, "R6", 1'b0);
        chk(last_cos == 0, "R6", "default tuple", last_cos, 0);
        dom_req(3, 0, 8'h0f, "", 1'b0);
        dom_req(3, 0, 8'h03, "R5", 1'b0);
        chk(last_cos == 1, "R5", "in-place cos", last_cos, 1);
        dom_req(4, 0, 8'hc0, "", 1'b0);
        dom_req(5, 0, 8'h3c, "R7", 1'b0);
        chk(last_stat == 1, "R7", "L2 range exhausted", last_stat, 1);
        dom_req(5, 1, 8'h0f, "R7", 1'b0);
        chk(last_cos == 4, "R7", "L3 range beyond L2", last_cos, 4);
        issue(6, 0, 8'hff, "R9", 1'b0);
        sweep(250, 1);

        // code/data mode
        do_reset(1'b1, 1'b1);
        dom_req(0, 2, 8'h0f, "R4", 1'b0);
        dom_req(1, 2, 8'hf0, "R4", 1'b0);
        dom_req(2, 2, 8'h3c, "R4", 1'b0);
        dom_req(3, 2, 8'hc0, "R7", 1'b0);
        chk(last_stat == 1, "R7", "halved L3 limit", last_stat, 1);
        dom_req(0, 1, 8'h03, "R5", 1'b0);
        dom_req(3, 0, 8'h0f, "R8", 1'b0);
        sweep(250, 2);

        // L3 off
        do_reset(1'b0, 1'b0);
        dom_req(0, 1, 8'h0f, "R9", 1'b0);
        dom_req(0, 0, 8'h0f, "R4", 1'b0);
        sweep(250, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule